// File: doc/BRIEF.md
# Configuration Access Address Translator

This block takes one configuration-space request and works out how it leaves the chip through a single outbound translation region. A request names a bus, a device, a function and a register offset, says whether it reads or writes, and gives an access size. The block reports five things for it: the local address to issue, the region type code, the target value to load into the region, the byte enables, and a flag that marks an illegal device number.

Requests to bus 0 go to the controller's own register block. Requests to any other bus go through a 1 MB configuration window at the top of a 16 MB aperture, and the target value carries the routing fields. Device numbers that cannot exist behind the root port are refused before any access. The result sits in an output register behind a one-deep valid/ready handshake. While a read result is held, the block extracts the requested byte or halfword lane from the dword that comes back. A refused read returns all ones.

Top module: `cfg_xlate`

## Requirements
- R1: `rsp_type` is 4 (config type 0) for bus 0 and bus 1, and 5 (config type 1) for bus 2 and above.
- R2: `rsp_addr` is the offset with bits 1:0 cleared, added to `LOCAL_BASE` (default 0x01FFC000) for bus 0. For any other bus it is added to the window base, `APER_BASE + 2^APER_LOG2 - 2^WIN_LOG2` (default 0x01F00000).
- R3: `rsp_target` is {bus[7:0], dev[4:0], fn[2:0], 16'h0} for a nonzero bus, and zero for bus 0.
- R4: `rsp_reject` is set for bus 0 with device above 1, and for bus 1 with any device other than 0. It is clear otherwise.
- R5: A refused request has `rsp_be` = 0 and `rsp_region_en` = 0. While a refused read is held, `cpl_data` is 0xFFFFFFFF.
- R6: An accepted request has `rsp_region_en` = 1. This is the region enable, bit 31 of the region's second control word.
- R7: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = dword. The lane is offset[1:0] for a byte, {offset[1],0} for a halfword, and 0 for a dword. `rsp_be` is 4'b0001, 4'b0011 or 4'b1111 shifted left by the lane.
- R8: `rsp_wdata` is `req_wdata` shifted left by 8 times the lane.
- R9: While an accepted read is held, `cpl_data` is `cpl_dword` shifted right by 8 times the lane, masked to 8, 16 or 32 bits. With no read held, `cpl_data` is 0.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request appears on the outputs one cycle later. A held response stays unchanged while `rsp_ready` is low.
- R11: During reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | AW | Local address to issue |
| rsp_type | output | 3 | Region type code |
| rsp_target | output | 32 | Region target value |
| rsp_region_en | output | 1 | Region enable |
| rsp_reject | output | 1 | Illegal device number |
| rsp_wr | output | 1 | Direction of the held request |
| rsp_be | output | 4 | Byte enables |
| rsp_wdata | output | 32 | Write data placed in its lane |
| cpl_dword | input | 32 | Dword returned for the held read |
| cpl_data | output | 32 | Extracted read data |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 12-bit offset, the local base at 0x01FFC000 and a 16 MB aperture at 0x01000000 whose top 1 MB forms the window. The 12-bit offset lets the bench reach offsets up to 0xFFF, so the clearing of the low bits and the base addition get exercised across the whole extended range. The fixed bases let the model compute every address from plain integer arithmetic. Random back-pressure holds responses for several cycles, which puts the stall path and the lane extraction during a stall within reach.

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter int AW = 32,
  parameter int OFF_W = 12,
  parameter logic [AW-1:0] LOCAL_BASE = 32'h01FF_C000,
  parameter logic [AW-1:0] APER_BASE = 32'h0100_0000,
  parameter int APER_LOG2 = 24,
  parameter int WIN_LOG2 = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_fn,
  input  logic [OFF_W-1:0] req_off,
  input  logic             req_wr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [AW-1:0]    rsp_addr,
  output logic [2:0]       rsp_type,
  output logic [31:0]      rsp_target,
  output logic             rsp_region_en,
  output logic             rsp_reject,
  output logic             rsp_wr,
  output logic [3:0]       rsp_be,
  output logic [31:0]      rsp_wdata,
  input  logic [31:0]      cpl_dword,
  output logic [31:0]      cpl_data
);
  localparam logic [AW-1:0] APER_SPAN = AW'(64'd1 << APER_LOG2);
  localparam logic [AW-1:0] WIN_SPAN  = AW'(64'd1 << WIN_LOG2);
  localparam logic [AW-1:0] WIN_BASE  = APER_BASE + APER_SPAN - WIN_SPAN;
  localparam logic [2:0] T_CFG0 = 3'd4;
  localparam logic [2:0] T_CFG1 = 3'd5;

  logic            bus0, bus1, bad;
  logic [1:0]      lane;
  logic [3:0]      mask;
  logic [OFF_W-1:0] off_al;
  logic [1:0]      lane_q, size_q;

  assign bus0   = (req_bus == 8'd0);
  assign bus1   = (req_bus == 8'd1);
  assign bad    = (bus0 && req_dev > 5'd1) || (bus1 && req_dev != 5'd0);
  assign off_al = {req_off[OFF_W-1:2], 2'b00};

  always_comb begin
    case (req_size)
      2'd0:    begin lane = req_off[1:0];      mask = 4'b0001; end
      2'd1:    begin lane = {req_off[1], 1'b0}; mask = 4'b0011; end
      default: begin lane = 2'd0;              mask = 4'b1111; end
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_addr      <= '0;
      rsp_type      <= 3'd0;
      rsp_target    <= 32'd0;
      rsp_region_en <= 1'b0;
      rsp_reject    <= 1'b0;
      rsp_wr        <= 1'b0;
      rsp_be        <= 4'd0;
      rsp_wdata     <= 32'd0;
      lane_q        <= 2'd0;
      size_q        <= 2'd0;
    end else if (req_valid && req_ready) begin
      rsp_valid     <= 1'b1;
      rsp_addr      <= (bus0 ? LOCAL_BASE : WIN_BASE) + AW'(off_al);
      rsp_type      <= (req_bus < 8'd2) ? T_CFG0 : T_CFG1;
      rsp_target    <= bus0 ? 32'd0 : {req_bus, req_dev, req_fn, 16'h0000};
      rsp_region_en <= !bad;
      rsp_reject    <= bad;
      rsp_wr        <= req_wr;
      rsp_be        <= bad ? 4'd0 : (mask << lane);
      rsp_wdata     <= req_wdata << {lane, 3'b000};
      lane_q        <= lane;
      size_q        <= req_size;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  logic [31:0] shifted;
  assign shifted = cpl_dword >> {lane_q, 3'b000};

  always_comb begin
    if (!rsp_valid || rsp_wr)     cpl_data = 32'd0;
    else if (rsp_reject)          cpl_data = 32'hFFFF_FFFF;
    else if (size_q == 2'd0)      cpl_data = {24'd0, shifted[7:0]};
    else if (size_q == 2'd1)      cpl_data = {16'd0, shifted[15:0]};
    else                          cpl_data = shifted;
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int AW = 32,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [AW-1:0]    rsp_addr,
  input logic [2:0]       rsp_type,
  input logic [31:0]      rsp_target,
  input logic             rsp_region_en,
  input logic             rsp_reject,
  input logic             rsp_wr,
  input logic [3:0]       rsp_be,
  input logic [31:0]      rsp_wdata,
  input logic [31:0]      cpl_data
);
  // R10
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_target)
      && $stable(rsp_be) && $stable(rsp_wdata) && $stable(rsp_type));
  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_reject |-> rsp_be == 4'd0 && !rsp_region_en);
  // R5
  reject_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_reject && !rsp_wr |-> cpl_data == 32'hFFFF_FFFF);
  // R2
  dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[1:0] == 2'b00);
  // R7
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_reject |-> $countones(rsp_be) == 1 || $countones(rsp_be) == 2
      || rsp_be == 4'hF);
  // R1
  type1_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_type == 3'd5 |-> rsp_target[31:24] >= 8'd2);
  // R6
  region_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_reject |-> rsp_region_en);
endmodule

bind cfg_xlate cfg_xlate_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/cfg_xlate_bench.sv
module cfg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_bus = 8'd0;
  logic [4:0]  req_dev = 5'd0;
  logic [2:0]  req_fn = 3'd0;
  logic [11:0] req_off = 12'd0;
  logic        req_wr = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_addr, rsp_target, rsp_wdata, cpl_data;
  logic [31:0] cpl_dword = 32'd0;
  logic [2:0]  rsp_type;
  logic        rsp_region_en, rsp_reject, rsp_wr;
  logic [3:0]  rsp_be;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cfg_xlate u_cfg_xlate (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference state
  bit          m_v = 0;
  int          m_bus, m_dev, m_fn, m_off, m_size, m_wr;
  longint      m_wdata;

  function automatic bit refused(int b, int d);
    return (b == 0 && d > 1) || (b == 1 && d != 0);
  endfunction

  function automatic int lane_of(int off, int sz);
    if (sz == 0) return off % 4;
    if (sz == 1) return (off % 4) / 2 * 2;
    return 0;
  endfunction

  function automatic int width_of(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic compare_outputs();
    int ln;
    longint a, t;
    chk("R10 rsp_valid", 32'(rsp_valid), 32'(m_v));
    if (m_v) begin
      ln = lane_of(m_off, m_size);
      a = (m_bus == 0) ? 64'h01FF_C000 : (64'h0100_0000 + 16*1024*1024 - 1024*1024);
      a = a + (m_off / 4) * 4;
      chk("R2 rsp_addr", rsp_addr, 32'(a));
      chk("R1 rsp_type", 32'(rsp_type), (m_bus < 2) ? 32'd4 : 32'd5);
      t = (m_bus == 0) ? 0 : (longint'(m_bus) * 16777216 + m_dev * 524288 + m_fn * 65536);
      chk("R3 rsp_target", rsp_target, 32'(t));
      chk("R4 rsp_reject", 32'(rsp_reject), 32'(refused(m_bus, m_dev)));
      if (refused(m_bus, m_dev)) begin
        chk("R5 rsp_be", 32'(rsp_be), 32'd0);
        chk("R5 rsp_region_en", 32'(rsp_region_en), 32'd0);
      end else begin
        chk("R6 rsp_region_en", 32'(rsp_region_en), 32'd1);
        chk("R7 rsp_be", 32'(rsp_be), 32'(((1 << width_of(m_size)) - 1) << ln));
      end
      chk("R8 rsp_wdata", rsp_wdata, 32'((m_wdata << (8*ln)) & 64'hFFFF_FFFF));
      chk("R10 rsp_wr", 32'(rsp_wr), 32'(m_wr));
    end
  endtask

  function automatic logic [31:0] exp_cpl(logic [31:0] dw);
    longint v;
    if (!m_v || m_wr != 0) return 32'd0;
    if (refused(m_bus, m_dev)) return 32'hFFFF_FFFF;
    v = longint'(dw) >> (8 * lane_of(m_off, m_size));
    v = v % (64'd1 << (8 * width_of(m_size)));
    return 32'(v);
  endfunction

  task automatic set_req(int b, int d, int f, int o, int sz, int w, logic [31:0] wd);
    req_bus = 8'(b); req_dev = 5'(d); req_fn = 3'(f); req_off = 12'(o);
    req_size = 2'(sz); req_wr = w[0]; req_wdata = wd;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk("R11 req_ready in reset", 32'(req_ready), 32'd1);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit fire_in;
      @(negedge clk);
      compare_outputs();
      cpl_dword = $urandom;
      if (cyc < 24) begin
        rsp_ready = 1'b1;
        req_valid = 1'b1;
        case (cyc % 12)
          0:  set_req(0, 0, 0, 12'h000, 2, 0, 32'h0);
          1:  set_req(0, 1, 7, 12'h013, 0, 0, 32'h0);
          2:  set_req(0, 2, 0, 12'h004, 2, 0, 32'h0);
          3:  set_req(1, 0, 3, 12'hFFE, 1, 1, 32'h0000_BEEF);
          4:  set_req(1, 1, 0, 12'h010, 2, 1, 32'h1234_5678);
          5:  set_req(2, 31, 7, 12'hFFF, 0, 1, 32'h0000_00A5);
          6:  set_req(255, 16, 5, 12'h102, 1, 0, 32'h0);
          7:  set_req(1, 9, 2, 12'h007, 0, 0, 32'h0);
          8:  set_req(3, 0, 0, 12'h006, 1, 1, 32'h0000_CAFE);
          9:  set_req(0, 31, 0, 12'h000, 0, 1, 32'h0000_0011);
          10: set_req(2, 4, 1, 12'h03D, 3, 0, 32'h0);
          default: set_req(128, 0, 0, 12'h801, 0, 0, 32'h0);
        endcase
      end else begin
        int b, d;
        rsp_ready = ($urandom % 4) != 0;
        req_valid = ($urandom % 3) != 0;
        case ($urandom % 4)
          0: b = 0;
          1: b = 1;
          2: b = 2;
          default: b = $urandom % 256;
        endcase
        d = (($urandom % 2) == 0) ? ($urandom % 3) : ($urandom % 32);
        set_req(b, d, $urandom % 8, $urandom % 4096, $urandom % 4, $urandom % 2, $urandom);
      end
      #1;
      chk("R10 req_ready", 32'(req_ready), 32'(!m_v || rsp_ready));
      chk("R9 cpl_data", cpl_data, exp_cpl(cpl_dword));
      fire_in = req_valid && (!m_v || rsp_ready);
      if (fire_in) begin
        m_v = 1; m_bus = req_bus; m_dev = req_dev; m_fn = req_fn; m_off = req_off;
        m_size = req_size; m_wr = req_wr; m_wdata = longint'(req_wdata);
      end else if (rsp_ready) begin
        m_v = 0;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule